// File: doc/BRIEF.md
# MDIO Management Target Interface

This block is the device-side end of a two-wire serial management bus. The data line is shared between the master and its targets, and the block samples it on every rising edge of the management clock. The block waits for a run of ones and then for a start marker. After that it decodes a two-bit opcode, a 5-bit device address and a 5-bit register address. It answers only when the device address equals its own, which is set by a parameter.

On a write frame it shifts in sixteen data bits. It then gives the register address and data to a local register file as a strobe that lasts one cycle. On a read frame it asks the local register file for the addressed word and turns the shared line around. It then shifts the word out, most significant bit first, through an output value and an output enable that drive an external tri-state pad.

The local side runs in the management clock domain. A read request is a one-cycle pulse, and the returned word is sampled at the end of that same cycle.

Top module: `mdio_target`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, and after its release, `mdio_oe`, `mdio_o`, `wr_stb` and `rd_req` are all 0.
- R2: A frame is recognised only after at least 32 consecutive ones. A 0 seen before the count reaches 32 restarts the count. A run of 31 ones followed by a well-formed frame produces no strobe, no request and no drive. Runs longer than 32 ones are accepted.
- R3: The start marker must be 0 then 1. Any other start pattern causes the frame to be ignored: no strobe, no request, no drive.
- R4: Opcode 0 then 1 is a write and opcode 1 then 0 is a read. Opcodes 00 and 11 cause the frame to be ignored.
- R5: The 5-bit device address and the 5-bit register address each arrive most significant bit first. A frame whose device address differs from `PHY_ADDR` causes no strobe and no request, and `mdio_oe` stays 0 for the whole frame.
- R6: A write produces exactly one `wr_stb` pulse, in the cycle after the rising edge that samples the 16th data bit. During that pulse `wr_addr` is the register address and `wr_data` is the data word, assembled MSB first.
- R7: A read produces exactly one `rd_req` pulse, in the cycle after the rising edge that samples the last register-address bit, with `rd_addr` equal to the register address. `rd_data` is taken at the end of that cycle.
- R8: During a read turnaround, `mdio_oe` is 0 through the first turnaround bit time. For the second turnaround bit time `mdio_oe` is 1 and `mdio_o` is 0.
- R9: In the 16 bit times after the turnaround, `mdio_o` carries the fetched word MSB first, with `mdio_oe` at 1. `mdio_oe` returns to 0 in the bit time that follows, so it is high for exactly 17 bit times per read.
- R10: After a frame ends, the block again waits for 32 ones. Idle ones count toward the next preamble, so frames can follow each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; everything updates on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mdio_i | input | 1 | Value seen on the shared data line |
| mdio_o | output | 1 | Value to drive onto the shared data line |
| mdio_oe | output | 1 | Output enable of the pad driver, 1 = drive |
| rd_req | output | 1 | One-cycle read request to the local register file |
| rd_addr | output | 5 | Register address of the read request |
| rd_data | input | 16 | Word returned by the local register file during `rd_req` |
| wr_stb | output | 1 | One-cycle write strobe to the local register file |
| wr_addr | output | 5 | Register address of the write |
| wr_data | output | 16 | Data word of the write |

## Verification
The assertions take for granted that `mdio_i` changes only away from the rising clock edge. They also assume that the local register file returns `rd_data` within the cycle in which `rd_req` is high. The bench meets the first assumption by changing `mdio_i` only on falling edges. It meets the second by returning a word computed combinationally from `rd_addr`. Between frames the bench sends a single 0 guard bit, so the leftover ones from the previous frame never add to the preamble of the next one. Random frames keep a valid start marker, and the malformed start patterns are chosen so that a misplaced bit cannot look like a valid start.

// File: rtl/mdio_target_pkg.sv
package mdio_target_pkg;

  typedef enum logic [2:0] {
    FS_PRE,
    FS_SOF,
    FS_HDR,
    FS_TA,
    FS_DATA
  } fstate_t;

  localparam int OP_BITS = 2;
  localparam int TA_BITS = 2;

  function automatic logic op_is_write(input logic [1:0] op);
    return op == 2'b01;
  endfunction

  function automatic logic op_is_read(input logic [1:0] op);
    return op == 2'b10;
  endfunction

  function automatic logic op_is_valid(input logic [1:0] op);
    return op_is_write(op) || op_is_read(op);
  endfunction

endpackage

// File: rtl/mdio_preamble.sv
module mdio_preamble #(
  parameter int PRE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  input  logic clr,
  output logic pre_done
);
  localparam int CW = $clog2(PRE_LEN + 1);

  logic [CW-1:0] ones_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else if (clr || !bit_i) begin
      ones_q <= '0;
    end else if (ones_q != CW'(PRE_LEN)) begin
      ones_q <= ones_q + 1'b1;
    end
  end

  assign pre_done = (ones_q == CW'(PRE_LEN));

  AST_PRE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_done && bit_i && !clr) |=> pre_done); // R2

  AST_PRE_ZERO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_i) |=> !pre_done); // R2

endmodule

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl
  import mdio_target_pkg::*;
#(
  parameter int              ADDR_W   = 5,
  parameter int              DATA_W   = 16,
  parameter logic [ADDR_W-1:0] PHY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              pre_done,
  output logic              in_pre,
  output logic              rd_req,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              ev_rd_load,
  output logic              ev_rd_shift,
  output logic              ev_rd_end
);
  localparam int HDR_BITS = OP_BITS + 2 * ADDR_W;
  localparam int CNT_MAX  = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;
  localparam int CW       = $clog2(CNT_MAX) + 1;

  fstate_t           st_q;
  logic [CW-1:0]     bitn_q;
  logic [HDR_BITS-1:0] hdr_q;
  logic [DATA_W-1:0] wsh_q;
  logic              is_rd_q;

  logic [HDR_BITS-1:0] hdr_word;
  logic [ADDR_W-1:0]   phy_field;
  logic [ADDR_W-1:0]   reg_field;
  logic [1:0]          op_field;
  logic                ev_start;
  logic                ev_hdr_last;
  logic                ev_data_last;

  assign hdr_word     = {hdr_q[HDR_BITS-2:0], bit_i};
  assign phy_field    = hdr_word[2*ADDR_W-1:ADDR_W];
  assign reg_field    = hdr_word[ADDR_W-1:0];
  assign op_field     = {hdr_q[0], bit_i};
  assign ev_start     = (st_q == FS_SOF) && bit_i;
  assign ev_hdr_last  = (st_q == FS_HDR) && (bitn_q == CW'(HDR_BITS - 1));
  assign ev_data_last = (st_q == FS_DATA) && (bitn_q == CW'(DATA_W - 1));

  assign in_pre      = (st_q == FS_PRE);
  assign ev_rd_load  = is_rd_q && (st_q == FS_TA) && (bitn_q == '0);
  assign ev_rd_shift = is_rd_q && (((st_q == FS_TA) && (bitn_q == CW'(TA_BITS - 1))) ||
                                   ((st_q == FS_DATA) && !ev_data_last));
  assign ev_rd_end   = is_rd_q && ev_data_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= FS_PRE;
      bitn_q   <= '0;
      hdr_q    <= '0;
      wsh_q    <= '0;
      is_rd_q  <= 1'b0;
      rd_req   <= 1'b0;
      wr_stb   <= 1'b0;
      reg_addr <= '0;
      wr_data  <= '0;
    end else begin
      rd_req <= 1'b0;
      wr_stb <= 1'b0;
      unique case (st_q)
        FS_PRE: begin
          if (!bit_i && pre_done) st_q <= FS_SOF;
        end
        FS_SOF: begin
          bitn_q <= '0;
          st_q   <= ev_start ? FS_HDR : FS_PRE;
        end
        FS_HDR: begin
          hdr_q  <= hdr_word;
          bitn_q <= bitn_q + 1'b1;
          if (bitn_q == CW'(OP_BITS - 1)) begin
            if (!op_is_valid(op_field)) st_q <= FS_PRE;
            is_rd_q <= op_is_read(op_field);
          end
          if (ev_hdr_last) begin
            bitn_q <= '0;
            if (phy_field == PHY_ADDR) begin
              st_q     <= FS_TA;
              reg_addr <= reg_field;
              rd_req   <= is_rd_q;
            end else begin
              st_q <= FS_PRE;
            end
          end
        end
        FS_TA: begin
          bitn_q <= bitn_q + 1'b1;
          if (bitn_q == CW'(TA_BITS - 1)) begin
            bitn_q <= '0;
            st_q   <= FS_DATA;
          end
        end
        FS_DATA: begin
          wsh_q  <= {wsh_q[DATA_W-2:0], bit_i};
          bitn_q <= bitn_q + 1'b1;
          if (ev_data_last) begin
            st_q <= FS_PRE;
            if (!is_rd_q) begin
              wr_stb  <= 1'b1;
              wr_data <= {wsh_q[DATA_W-2:0], bit_i};
            end
          end
        end
        default: st_q <= FS_PRE;
      endcase
    end
  end

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R6

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R7

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_stb)); // R6

  AST_REQ_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ev_rd_load); // R7

endmodule

// File: rtl/mdio_read_drv.sv
module mdio_read_drv #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (load) begin
      sh_q    <= rd_data;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b1;
    end else if (shift) begin
      sh_q    <= {sh_q[DATA_W-2:0], 1'b0};
      mdio_o  <= sh_q[DATA_W-1];
    end else if (done) begin
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end
  end

  AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o); // R8

  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mdio_oe); // R9

endmodule

// File: rtl/mdio_target.sv
module mdio_target #(
  parameter int                ADDR_W   = 5,
  parameter int                DATA_W   = 16,
  parameter int                PRE_LEN  = 32,
  parameter logic [ADDR_W-1:0] PHY_ADDR = 5'h0B
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic              pre_done;
  logic              in_pre;
  logic              ev_rd_load;
  logic              ev_rd_shift;
  logic              ev_rd_end;
  logic [ADDR_W-1:0] reg_addr;

  mdio_preamble #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk      (mdc),
    .rst_n    (rst_n),
    .bit_i    (mdio_i),
    .clr      (!in_pre),
    .pre_done (pre_done)
  );

  mdio_frame_ctl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PHY_ADDR (PHY_ADDR)
  ) u_ctl (
    .clk         (mdc),
    .rst_n       (rst_n),
    .bit_i       (mdio_i),
    .pre_done    (pre_done),
    .in_pre      (in_pre),
    .rd_req      (rd_req),
    .wr_stb      (wr_stb),
    .reg_addr    (reg_addr),
    .wr_data     (wr_data),
    .ev_rd_load  (ev_rd_load),
    .ev_rd_shift (ev_rd_shift),
    .ev_rd_end   (ev_rd_end)
  );

  mdio_read_drv #(.DATA_W(DATA_W)) u_drv (
    .clk     (mdc),
    .rst_n   (rst_n),
    .load    (ev_rd_load),
    .shift   (ev_rd_shift),
    .done    (ev_rd_end),
    .rd_data (rd_data),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

  assign rd_addr = reg_addr;
  assign wr_addr = reg_addr;

  AST_DRIVE_AFTER_REQ: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> $past(rd_req)); // R8

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_stb |-> !mdio_oe); // R5

endmodule

// File: tb/mdio_target_tb_top.sv
module mdio_target_tb_top;
  localparam logic [4:0] MY_PHY = 5'h0B;

  logic        mdc = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdio_i = 1'b1;
  logic        mdio_o, mdio_oe, rd_req, wr_stb;
  logic [4:0]  rd_addr, wr_addr;
  logic [15:0] rd_data, wr_data;

  int n_chk = 0, n_bad = 0;
  int n_stb = 0, n_req = 0, n_oe = 0;
  logic [4:0]  cap_addr;
  logic [15:0] cap_data;

  always #4 mdc = ~mdc;

  function automatic logic [15:0] exp_rd(input logic [4:0] a);
    return {a, a, a, a[0]} ^ 16'h5A3C;
  endfunction

  assign rd_data = exp_rd(rd_addr);

  mdio_target #(.PHY_ADDR(MY_PHY)) dut_i (
    .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge mdc) begin
    if (wr_stb) begin n_stb++; cap_addr = wr_addr; cap_data = wr_data; end
    if (rd_req) n_req++;
    if (mdio_oe) n_oe++;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    @(negedge mdc);
    #1 mdio_i = v;
  endtask

  task automatic frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] wd, input string req);
    int s0, r0, o0;
    logic acc, is_wr, is_rdf, ta_ok;
    logic [15:0] got;
    acc    = (pre >= 32) && (st == 2'b01) && (op == 2'b01 || op == 2'b10) && (phy == MY_PHY);
    is_wr  = acc && (op == 2'b01);
    is_rdf = acc && (op == 2'b10);
    send_bit(1'b0);
    s0 = n_stb; r0 = n_req; o0 = n_oe;
    for (int i = 0; i < pre; i++) send_bit(1'b1);
    send_bit(st[1]); send_bit(st[0]);
    send_bit(op[1]); send_bit(op[0]);
    for (int i = 4; i >= 0; i--) send_bit(phy[i]);
    for (int i = 4; i >= 0; i--) send_bit(ra[i]);
    send_bit(op == 2'b10 ? 1'b1 : 1'b1);
    ta_ok = 1'b1;
    if (is_rdf) begin
      chk(!mdio_oe && rd_req && rd_addr == ra, "R7 rd_req/addr",
          {rd_req, mdio_oe, rd_addr}, {2'b10, ra});
    end
    send_bit(op == 2'b10 ? 1'b1 : 1'b0);
    if (is_rdf) chk(mdio_oe && !mdio_o, "R8 turnaround", {mdio_oe, mdio_o}, 2'b10);
    got = '0;
    for (int i = 15; i >= 0; i--) begin
      send_bit(op == 2'b10 ? 1'b1 : wd[i]);
      got[i] = mdio_o;
      if (is_rdf && !mdio_oe) ta_ok = 1'b0;
    end
    if (is_rdf) chk(ta_ok && got == exp_rd(ra), "R9 read data", got, exp_rd(ra));
    send_bit(1'b1);
    if (is_rdf) chk(!mdio_oe, "R9 release", mdio_oe, 0);
    if (is_wr) chk(wr_stb && wr_addr == ra && wr_data == wd, "R6 write strobe",
                   {wr_stb, wr_addr, wr_data}, {1'b1, ra, wd});
    send_bit(1'b1);
    chk((n_stb - s0) == int'(is_wr) && (n_req - r0) == int'(is_rdf) &&
        (n_oe - o0) == (is_rdf ? 17 : 0), req,
        {8'(n_stb - s0), 8'(n_req - r0), 16'(n_oe - o0)},
        {8'(is_wr), 8'(is_rdf), 16'(is_rdf ? 17 : 0)});
  endtask

  logic done = 1'b0;

  initial begin
    int seed;
    logic [4:0] p;
    seed = 32'h1D5E7;
    void'($urandom(seed));
    #2;
    chk(!mdio_oe && !mdio_o && !wr_stb && !rd_req, "R1 in reset",
        {mdio_oe, mdio_o, wr_stb, rd_req}, 0);
    repeat (3) @(negedge mdc);
    rst_n = 1'b1;
    repeat (2) @(negedge mdc);
    chk(!mdio_oe && !mdio_o && !wr_stb && !rd_req, "R1 after reset",
        {mdio_oe, mdio_o, wr_stb, rd_req}, 0);

    frame(32, 2'b01, 2'b01, MY_PHY, 5'h05, 16'hBEEF, "R6 write frame");
    frame(32, 2'b01, 2'b10, MY_PHY, 5'h05, 16'h0000, "R7 read frame");
    frame(32, 2'b01, 2'b10, MY_PHY, 5'h1F, 16'h0000, "R9 read top reg");
    frame(31, 2'b01, 2'b01, MY_PHY, 5'h02, 16'h1234, "R2 short preamble write");
    frame(31, 2'b01, 2'b10, MY_PHY, 5'h02, 16'h0000, "R2 short preamble read");
    frame(40, 2'b01, 2'b01, MY_PHY, 5'h11, 16'hFFFF, "R2 long preamble");
    frame(32, 2'b00, 2'b01, MY_PHY, 5'h03, 16'h5555, "R3 start 00");
    frame(32, 2'b10, 2'b01, MY_PHY, 5'h03, 16'h5555, "R3 start 10");
    frame(32, 2'b01, 2'b00, MY_PHY, 5'h04, 16'hAAAA, "R4 opcode 00");
    frame(32, 2'b01, 2'b11, MY_PHY, 5'h04, 16'hAAAA, "R4 opcode 11");
    frame(32, 2'b01, 2'b10, MY_PHY ^ 5'h01, 5'h06, 16'h0000, "R5 foreign read");
    frame(32, 2'b01, 2'b01, MY_PHY ^ 5'h10, 5'h06, 16'h0F0F, "R5 foreign write");
    frame(32, 2'b01, 2'b01, MY_PHY, 5'h00, 16'h8001, "R10 back to back");

    for (int k = 0; k < 40; k++) begin
      p = ($urandom % 2) ? MY_PHY : 5'($urandom);
      frame(32 + int'($urandom % 6), 2'b01, 2'($urandom), p, 5'($urandom),
            16'($urandom), "R10 random frame");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule